// File: doc/BRIEF.md
# Byte engine with strong pull-up

This block moves whole bytes over a single-wire bus by driving a bit-slot engine below it one slot at a time. It accepts three byte commands: write, read and touch. A write sends eight data bits; a read sends eight slots carrying a 1 and collects what the bus returns; a touch sends the data bits and replaces each one with the level sampled in its own slot. Bits always travel least significant first, and slot `i` maps to byte position `i`.

The block also handles a one-shot strong pull-up request. Software writes a duration in milliseconds into the duration register. The next write or touch then uses that request. When the hardware pull-up is enabled, the block turns the pull-up output on just before the eighth slot. It keeps the output on for the programmed time after the last slot. It then turns the output off, clears the request and reports done. When the hardware pull-up is disabled, the block waits the same time with the pull-up off. A read never uses the request. Writing zero to the register cancels a pending request.

Top module: `ow_byte_engine`

## Requirements
- R1: After reset, `done`, `busy`, `slot_req` and `pu_on` are all low.
- R2: The command codes are 01 for write, 10 for read and 11 for touch, and code 00 is ignored. In a write, slot `i` (i = 0 first) sends bit `i` of `cmd_data`.
- R3: A read issues eight slots that each send 1. Bit `i` of `rx_byte` is the level sampled in slot `i`.
- R4: A touch sends bit `i` of `cmd_data` in slot `i`. Bit `i` of `rx_byte` is the level sampled in slot `i`.
- R5: A pull-up request is pending when the duration register is non-zero. If a request is pending and `hw_pu_en` is high, a write or touch raises `pu_on` before the eighth slot starts and keeps it low during slots 0 to 6.
- R6: In the R5 case, `pu_on` stays high for exactly `ms*TICKS_PER_MS` cycles after the cycle in which the last `slot_done` is taken. `done` rises in the cycle after that, with `pu_on` low.
- R7: With a request pending and `hw_pu_en` low, `pu_on` never rises. `done` is still delayed by `ms*TICKS_PER_MS` cycles after the last slot.
- R8: A write or touch that used a request clears the duration register. The next write then completes without a pull-up or a wait.
- R9: Writing zero to the duration register cancels a pending request.
- R10: A read neither uses nor clears a pending request: no pull-up, no wait, and the request stays pending for the next write.
- R11: When no request is used, `done` is a one-cycle pulse in the cycle after the last `slot_done`. `busy` is high from command accept to `done`, and `slot_req` is asserted only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 01 write, 10 read, 11 touch, 00 ignored |
| cmd_data | input | 8 | Byte to send (write, touch) |
| pu_wr | input | 1 | Load the duration register (taken when idle) |
| pu_ms | input | DUR_W | Pull-up duration in milliseconds, 0 cancels |
| hw_pu_en | input | 1 | Strong pull-up hardware enabled |
| slot_done | input | 1 | Bit-slot engine finished the current slot |
| slot_sample | input | 1 | Bus level sampled in the finished slot |
| slot_req | output | 1 | Request a slot, held until slot_done |
| slot_bit | output | 1 | Bit value for the requested slot |
| pu_on | output | 1 | Strong pull-up enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Sampled byte |

## Verification
The bench builds the block with `DUR_W = 4` and `TICKS_PER_MS = 5`. A 3 ms hold is then only 15 cycles, so the bench can count the hold time and the done latency exactly in both pull-up modes. The small register width still covers durations 1 to 3 and the zero-cancel case. A slot model with a fixed three-cycle latency records the bit sent and the pull-up level at the start of each slot. This lets the bench check the eighth-slot timing of the pull-up directly.

// File: rtl/ow_byte_engine.sv
module ow_byte_engine #(
  parameter int DUR_W        = 8,
  parameter int TICKS_PER_MS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             pu_wr,
  input  logic [DUR_W-1:0] pu_ms,
  input  logic             hw_pu_en,
  input  logic             slot_done,
  input  logic             slot_sample,
  output logic             slot_req,
  output logic             slot_bit,
  output logic             pu_on,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  localparam int TW = $clog2(TICKS_PER_MS + 1);
  localparam int CW = DUR_W + TW;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_HOLD, S_DONE} st_t;

  st_t             st;
  logic [1:0]      op_q;
  logic [7:0]      data_q;
  logic [7:0]      rx_q;
  logic [2:0]      idx;
  logic [DUR_W-1:0] dur_q;
  logic            use_pu;
  logic [CW-1:0]   hold_cnt;
  logic            pu_q;

  assign slot_req = (st == S_SLOT);
  assign slot_bit = (op_q == OP_RD) ? 1'b1 : data_q[idx];
  assign pu_on    = pu_q;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign rx_byte  = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      data_q   <= '0;
      rx_q     <= '0;
      idx      <= '0;
      dur_q    <= '0;
      use_pu   <= 1'b0;
      hold_cnt <= '0;
      pu_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_valid && cmd_op != 2'b00) begin
            op_q   <= cmd_op;
            data_q <= cmd_data;
            idx    <= '0;
            use_pu <= (cmd_op != OP_RD) && (dur_q != '0);
            st     <= S_SLOT;
          end else if (pu_wr) begin
            dur_q <= pu_ms;
          end
        end
        S_SLOT: begin
          if (slot_done) begin
            rx_q[idx] <= slot_sample;
            idx       <= idx + 3'd1;
            if (idx == 3'd6 && use_pu && hw_pu_en)
              pu_q <= 1'b1;
            if (idx == 3'd7) begin
              if (use_pu) begin
                hold_cnt <= CW'(dur_q) * CW'(TICKS_PER_MS) - CW'(1);
                st       <= S_HOLD;
              end else begin
                st <= S_DONE;
              end
            end
          end
        end
        S_HOLD: begin
          if (hold_cnt == '0) begin
            pu_q  <= 1'b0;
            dur_q <= '0;
            st    <= S_DONE;
          end else begin
            hold_cnt <= hold_cnt - CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_byte_engine_chk.sv
module ow_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       pu_on,
  input logic       slot_req,
  input logic       slot_bit,
  input logic [1:0] op_q
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!slot_req && !pu_on));

  assert_pu_rise_at_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pu_on) |-> slot_req);

  assert_pu_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pu_on) |-> done);

  assert_read_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && op_q == 2'b10) |-> slot_bit);
endmodule

bind ow_byte_engine ow_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pu_on(pu_on),
  .slot_req(slot_req), .slot_bit(slot_bit), .op_q(op_q)
);

// File: tb/ow_byte_engine_bench.sv
module ow_byte_engine_bench;
  localparam int DW  = 4;
  localparam int TPM = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [7:0]    cmd_data = 8'h00;
  logic          pu_wr = 1'b0;
  logic [DW-1:0] pu_ms = '0;
  logic          hw_pu_en = 1'b0;
  logic          slot_done = 1'b0;
  logic          slot_sample = 1'b0;
  logic          slot_req, slot_bit, pu_on, busy, done;
  logic [7:0]    rx_byte;

  always #4 clk = ~clk;

  ow_byte_engine #(.DUR_W(DW), .TICKS_PER_MS(TPM)) u_ow_byte_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .pu_wr(pu_wr), .pu_ms(pu_ms), .hw_pu_en(hw_pu_en),
    .slot_done(slot_done), .slot_sample(slot_sample), .slot_req(slot_req),
    .slot_bit(slot_bit), .pu_on(pu_on), .busy(busy), .done(done),
    .rx_byte(rx_byte)
  );

  typedef struct {
    string      tag;
    logic       chk_rx;
    logic [7:0] rx;
    logic [7:0] sent;
    logic [7:0] pu_mask;
    int         lat;
    int         pucnt;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int pend = 0;
  logic [7:0] resp = 8'hFF;
  bit finished = 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic arm(int ms);
    @(negedge clk);
    pu_wr = 1'b1; pu_ms = DW'(ms);
    @(negedge clk);
    pu_wr = 1'b0;
    pend = ms;
  endtask

  task automatic run(string tag, logic [1:0] op, logic [7:0] data,
                     logic [7:0] rsp, logic hw);
    exp_t e;
    logic [7:0] s;
    logic used;
    s = (op == 2'b10) ? 8'hFF : data;
    used = (op != 2'b10) && (pend != 0);
    e.tag = tag;
    e.chk_rx = (op != 2'b01);
    e.sent = s;
    e.rx = s & rsp;
    e.pu_mask = (used && hw) ? 8'h80 : 8'h00;
    e.lat = used ? pend * TPM + 1 : 1;
    e.pucnt = (used && hw) ? pend * TPM : 0;
    if (used) pend = 0;
    q.push_back(e);
    @(negedge clk);
    resp = rsp; hw_pu_en = hw;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : slot_and_monitor
    int since = 0, pucnt = 0, wcnt = 0, bitn = 0;
    logic [7:0] sent = '0, pu_at = '0;
    logic sd;
    exp_t e;
    forever begin
      @(negedge clk);
      if (slot_done) begin since = 0; pucnt = 0; end
      since++;
      if (pu_on) pucnt++;
      sd = 1'b0;
      if (slot_req) begin
        wcnt++;
        if (wcnt == 1 && bitn < 8) pu_at[bitn] = pu_on;
        if (wcnt == 3) begin
          if (bitn < 8) begin
            sent[bitn] = slot_bit;
            slot_sample = slot_bit & resp[bitn];
          end
          sd = 1'b1;
          bitn++;
          wcnt = 0;
        end
      end
      slot_done = sd;
      if (done) begin
        if (q.size() == 0) begin
          chk("R11 unexpected done", 1, 0);
        end else begin
          e = q.pop_front();
          chk({e.tag, " slot count"}, bitn, 8);
          chk({e.tag, " bits sent"}, sent, e.sent);
          if (e.chk_rx) chk({e.tag, " rx_byte"}, rx_byte, e.rx);
          chk({e.tag, " pull-up per slot"}, pu_at, e.pu_mask);
          chk({e.tag, " done latency"}, since, e.lat);
          chk({e.tag, " pull-up hold cycles"}, pucnt, e.pucnt);
          chk({e.tag, " pull-up off at done"}, pu_on, 0);
        end
        bitn = 0; sent = '0; pu_at = '0; wcnt = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk("watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 slot_req after reset", slot_req, 0);
    chk("R1 pu_on after reset", pu_on, 0);
    rst_n = 1'b1;
    @(negedge clk);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_data = 8'hAA;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 code 00 ignored busy", busy, 0);
    chk("R2 code 00 ignored slot_req", slot_req, 0);

    run("R2 R11 write lsb first", 2'b01, 8'hA5, 8'hFF, 1'b1);
    run("R3 read", 2'b10, 8'h00, 8'h3C, 1'b1);
    run("R4 touch", 2'b11, 8'h0F, 8'h55, 1'b1);

    arm(3);
    run("R5 R6 hw pull-up write", 2'b01, 8'h81, 8'hFF, 1'b1);
    run("R8 after one-shot", 2'b01, 8'h42, 8'hFF, 1'b1);

    arm(2);
    run("R7 soft wait write", 2'b01, 8'hC3, 8'hFF, 1'b0);
    run("R8 soft request cleared", 2'b01, 8'h3C, 8'hFF, 1'b0);

    arm(2);
    run("R10 read with pending", 2'b10, 8'h00, 8'hF0, 1'b1);
    run("R10 request kept for write", 2'b01, 8'h18, 8'hFF, 1'b1);

    arm(3);
    arm(0);
    run("R9 cancelled request", 2'b01, 8'h99, 8'hFF, 1'b1);

    arm(1);
    run("R5 R4 touch with pull-up", 2'b11, 8'hE7, 8'hA5, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule